// File: doc/BRIEF.md
# External Interrupt Controller Bank

The block collects a parameterized set of external interrupt lines (32 by default, in multiples of 32) and presents them to a processor as one combined interrupt. Each line passes through a synchronizer. It is then judged edge- or level-sensitive according to its own sensitivity and polarity bits. Pending events appear in a status word. Software can raise a line directly through a soft-interrupt bit.

All per-line control state is changed through write-one-to-set and write-one-to-clear addresses, so software never needs a read-modify-write. A separate acknowledge address clears latched edge events. A per-line enable word gates every line before the combined output. It resets to zero, so software must write it with all ones before any interrupt reaches the processor. Software that needs both edges flips the polarity bit after each event. A polarity change on a steady pin therefore never produces an event.

Top module: `eint_bank`

## Requirements
- R1: After reset the status, polarity, sensitivity, soft-interrupt and enable words all read 0, every mask bit reads 1 (1 = masked), and `irq_o` is 0.
- R2: Address is {group[3:0], word index, 2'b00}. Writing to a set group (mask 3, polarity 6, sensitivity 9, soft 12) ORs the written ones into that word. Writing to a clear group (4, 7, 10, 13) removes the written ones. Zero bits leave their lines unchanged. The current word reads back at group 2 (mask), 5 (polarity), 8 (sensitivity) and 11 (soft). The enable word at group 14 is written and read as a whole word.
- R3: Line n is bit n mod 32 of word n/32 in every group, and no other line is affected.
- R4: With sensitivity 0 (edge), a pin transition in the direction chosen by polarity latches the line's status bit (group 0), and the bit stays set after the pin returns. Polarity 1 selects rising and 0 selects falling. The opposite transition latches nothing.
- R5: With sensitivity 1 (level), the status bit equals (pin == polarity) while it holds, and an acknowledge has no effect on it.
- R6: Writing 1 to a bit of the acknowledge group (1) clears that line's latched edge status. Zero bits leave other latched lines set.
- R7: A set soft-interrupt bit forces the line's status to 1. It survives acknowledges until written through the soft-clear group.
- R8: Changing a line's polarity or sensitivity while its pin is steady latches no edge event.
- R9: `irq_o` is a registered OR over lines of (status AND NOT mask AND enable). It is 0 while all lines are masked or while the enable word is 0.
- R10: Reads return data one cycle after `reg_re`. Set, clear and acknowledge addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_LINES | Asynchronous external interrupt pins |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address {group, word, 2'b00} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt to the processor |

## Verification
The hardest case to reach from the ports is a polarity change on a pin that has been steady for many cycles. A design that compares levels after polarity has been applied turns this into a false edge. The stimulus parks a pin high and low, switches the polarity both ways through the set and clear addresses, and confirms that the status stays clear. A second difficult case is the interplay of acknowledge, soft interrupt and level mode on one line. For this, each line is brought to a pending state by a different route, and acknowledges are then issued that must clear only the latched edge.

// File: rtl/eint_pkg.sv
package eint_pkg;
  localparam int GRP_W  = 4;
  localparam int DATA_W = 32;

  typedef enum logic [GRP_W-1:0] {
    G_STATUS   = 4'd0,
    G_ACK      = 4'd1,
    G_MASK     = 4'd2,
    G_MASK_SET = 4'd3,
    G_MASK_CLR = 4'd4,
    G_POL      = 4'd5,
    G_POL_SET  = 4'd6,
    G_POL_CLR  = 4'd7,
    G_SENS     = 4'd8,
    G_SENS_SET = 4'd9,
    G_SENS_CLR = 4'd10,
    G_SOFT     = 4'd11,
    G_SOFT_SET = 4'd12,
    G_SOFT_CLR = 4'd13,
    G_ENABLE   = 4'd14,
    G_NONE     = 4'd15
  } grp_e;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/eint_edge_status.sv
module eint_edge_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] sens_i,
  input  logic [W-1:0] soft_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] edge_q;
  logic [W-1:0] rise, fall, hit, level_act;

  // Edges come from the raw synchronized pin, so a polarity change alone
  // never looks like a transition.
  assign rise      = sync_i & ~prev_q;
  assign fall      = ~sync_i & prev_q;
  assign hit       = (rise & pol_i) | (fall & ~pol_i);
  assign level_act = ~(sync_i ^ pol_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      edge_q <= '0;
    end else begin
      prev_q <= sync_i;
      edge_q <= ((edge_q & ~ack_i) | hit) & ~sens_i;
    end
  end

  assign edge_o   = edge_q;
  assign status_o = (sens_i & level_act) | (~sens_i & edge_q) | soft_i;
endmodule

// File: rtl/eint_regs.sv
module eint_regs
  import eint_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int WORDS     = NUM_LINES / DATA_W,
  parameter int WIDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we_i,
  input  grp_e                 grp_i,
  input  logic [WIDX_W-1:0]    word_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] pol_o,
  output logic [NUM_LINES-1:0] sens_o,
  output logic [NUM_LINES-1:0] soft_o,
  output logic [NUM_LINES-1:0] en_o,
  output logic [NUM_LINES-1:0] ack_o
);
  logic [NUM_LINES-1:0] mask_q, pol_q, sens_q, soft_q, en_q;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic sel;
    assign sel = we_i && (word_i == WIDX_W'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[w*DATA_W +: DATA_W] <= '1;
        pol_q [w*DATA_W +: DATA_W] <= '0;
        sens_q[w*DATA_W +: DATA_W] <= '0;
        soft_q[w*DATA_W +: DATA_W] <= '0;
        en_q  [w*DATA_W +: DATA_W] <= '0;
      end else if (sel) begin
        case (grp_i)
          G_MASK_SET: mask_q[w*DATA_W +: DATA_W] <= mask_q[w*DATA_W +: DATA_W] | wdata_i;
          G_MASK_CLR: mask_q[w*DATA_W +: DATA_W] <= mask_q[w*DATA_W +: DATA_W] & ~wdata_i;
          G_POL_SET:  pol_q [w*DATA_W +: DATA_W] <= pol_q [w*DATA_W +: DATA_W] | wdata_i;
          G_POL_CLR:  pol_q [w*DATA_W +: DATA_W] <= pol_q [w*DATA_W +: DATA_W] & ~wdata_i;
          G_SENS_SET: sens_q[w*DATA_W +: DATA_W] <= sens_q[w*DATA_W +: DATA_W] | wdata_i;
          G_SENS_CLR: sens_q[w*DATA_W +: DATA_W] <= sens_q[w*DATA_W +: DATA_W] & ~wdata_i;
          G_SOFT_SET: soft_q[w*DATA_W +: DATA_W] <= soft_q[w*DATA_W +: DATA_W] | wdata_i;
          G_SOFT_CLR: soft_q[w*DATA_W +: DATA_W] <= soft_q[w*DATA_W +: DATA_W] & ~wdata_i;
          G_ENABLE:   en_q  [w*DATA_W +: DATA_W] <= wdata_i;
          default: ;
        endcase
      end
    end

    assign ack_o[w*DATA_W +: DATA_W] = (sel && grp_i == G_ACK) ? wdata_i : '0;
  end

  assign mask_o = mask_q;
  assign pol_o  = pol_q;
  assign sens_o = sens_q;
  assign soft_o = soft_q;
  assign en_o   = en_q;
endmodule

// File: rtl/eint_bank.sv
module eint_bank
  import eint_pkg::*;
#(
  parameter int NUM_LINES   = 32,
  parameter int SYNC_STAGES = 2,
  localparam int WORDS      = NUM_LINES / DATA_W,
  localparam int WIDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int ADDR_W     = GRP_W + WIDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic                 reg_we,
  input  logic                 reg_re,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_o
);
  grp_e              grp;
  logic [WIDX_W-1:0] word;

  assign grp  = grp_e'(reg_addr[ADDR_W-1 -: GRP_W]);
  assign word = reg_addr[2 +: WIDX_W];

  logic [NUM_LINES-1:0] sync_w, mask_q, pol_q, sens_q, soft_q, en_q, ack_w;
  logic [NUM_LINES-1:0] edge_w, status_w;

  eint_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(sync_w)
  );

  eint_regs #(.NUM_LINES(NUM_LINES), .WORDS(WORDS), .WIDX_W(WIDX_W)) u_regs (
    .clk(clk), .rst(rst), .we_i(reg_we), .grp_i(grp), .word_i(word),
    .wdata_i(reg_wdata), .mask_o(mask_q), .pol_o(pol_q), .sens_o(sens_q),
    .soft_o(soft_q), .en_o(en_q), .ack_o(ack_w)
  );

  eint_edge_status #(.W(NUM_LINES)) u_stat (
    .clk(clk), .rst(rst), .sync_i(sync_w), .pol_i(pol_q), .sens_i(sens_q),
    .soft_i(soft_q), .ack_i(ack_w), .edge_o(edge_w), .status_o(status_w)
  );

  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (word == WIDX_W'(w)) begin
        case (grp)
          G_STATUS: rd_word = status_w[w*DATA_W +: DATA_W];
          G_MASK:   rd_word = mask_q  [w*DATA_W +: DATA_W];
          G_POL:    rd_word = pol_q   [w*DATA_W +: DATA_W];
          G_SENS:   rd_word = sens_q  [w*DATA_W +: DATA_W];
          G_SOFT:   rd_word = soft_q  [w*DATA_W +: DATA_W];
          G_ENABLE: rd_word = en_q    [w*DATA_W +: DATA_W];
          default:  rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      if (reg_re) reg_rdata <= rd_word;
      irq_o <= |(status_w & ~mask_q & en_q);
    end
  end
endmodule

// File: rtl/eint_bank_chk.sv
module eint_bank_chk #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 7,
  parameter int WIDX_W    = 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reg_we,
  input logic                 reg_re,
  input logic [ADDR_W-1:0]    reg_addr,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic                 irq_o,
  input logic [NUM_LINES-1:0] mask_q,
  input logic [NUM_LINES-1:0] en_q,
  input logic [NUM_LINES-1:0] soft_q,
  input logic [NUM_LINES-1:0] status_w,
  input logic [NUM_LINES-1:0] sync_w,
  input logic [NUM_LINES-1:0] edge_w
);
  logic [3:0] grp;
  logic       word0, write_only;
  assign grp   = reg_addr[ADDR_W-1 -: 4];
  assign word0 = reg_addr[2 +: WIDX_W] == '0;
  assign write_only = (grp == 4'd1) || (grp == 4'd3) || (grp == 4'd4) ||
                      (grp == 4'd6) || (grp == 4'd7) || (grp == 4'd9) ||
                      (grp == 4'd10) || (grp == 4'd12) || (grp == 4'd13);

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |=> !irq_o); // R9
  AST_NO_ENABLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0) |=> !irq_o); // R9
  AST_SOFT_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (soft_q & ~status_w) == '0); // R7
  AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (reg_we && grp == 4'd3 && word0) |=>
      ((mask_q[31:0] & $past(reg_wdata)) == $past(reg_wdata))); // R2
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_re && write_only) |=> (reg_rdata == '0)); // R10
  AST_NO_EDGE_WITHOUT_CHANGE: assert property (@(posedge clk) disable iff (rst)
    $stable(sync_w) |=> ((edge_w & ~$past(edge_w)) == '0)); // R8
endmodule

bind eint_bank eint_bank_chk #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .WIDX_W(WIDX_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_o(irq_o), .mask_q(mask_q), .en_q(en_q), .soft_q(soft_q),
  .status_w(status_w), .sync_w(sync_w), .edge_w(edge_w)
);

// File: tb/eint_bank_test.sv
module eint_bank_test;
  import eint_pkg::*;

  localparam int NL     = 64;
  localparam int WORDS  = NL / 32;
  localparam int WIDX_W = 1;
  localparam int ADDR_W = 4 + WIDX_W + 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NL-1:0]     pin = '0;
  logic              we = 1'b0, re = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  eint_bank #(.NUM_LINES(NL)) uut (
    .clk(clk), .rst(rst), .pin_i(pin), .reg_we(we), .reg_re(re),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq)
  );

  function automatic logic [ADDR_W-1:0] mk(grp_e g, int w);
    return {g, WIDX_W'(w), 2'b00};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(grp_e g, int w, logic [31:0] d);
    we = 1'b1; addr = mk(g, w); wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(grp_e g, int w, output logic [31:0] d);
    re = 1'b1; addr = mk(g, w);
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] model [4][WORDS];
    grp_e rg [4], sg [4], cg [4];
    rg = '{G_MASK, G_POL, G_SENS, G_SOFT};
    sg = '{G_MASK_SET, G_POL_SET, G_SENS_SET, G_SOFT_SET};
    cg = '{G_MASK_CLR, G_POL_CLR, G_SENS_CLR, G_SOFT_CLR};

    idle(4);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'd0, irq}, 32'd0);
    for (int w = 0; w < WORDS; w++) begin
      rd(G_STATUS, w, v); chk("R1 status", v, 32'h0);
      rd(G_MASK, w, v);   chk("R1 mask", v, 32'hFFFF_FFFF);
      rd(G_POL, w, v);    chk("R1 pol", v, 32'h0);
      rd(G_SENS, w, v);   chk("R1 sens", v, 32'h0);
      rd(G_SOFT, w, v);   chk("R1 soft", v, 32'h0);
      rd(G_ENABLE, w, v); chk("R1 enable", v, 32'h0);
    end

    // R2 / R3 set-clear sweep per group and word
    for (int g = 0; g < 4; g++)
      for (int w = 0; w < WORDS; w++)
        model[g][w] = (g == 0) ? 32'hFFFF_FFFF : 32'h0;
    for (int g = 0; g < 4; g++) begin
      for (int w = 0; w < WORDS; w++) begin
        logic [31:0] a, b;
        a = 32'hA5A5_0F0F ^ (32'h1111_1111 * (w + 1));
        b = 32'h3C3C_F00F ^ (32'h0101_0101 << w);
        wr(sg[g], w, a);
        model[g][w] |= a;
        for (int k = 0; k < WORDS; k++) begin
          rd(rg[g], k, v); chk("R2 set readback (R3 word isolation)", v, model[g][k]);
        end
        wr(cg[g], w, b);
        model[g][w] &= ~b;
        for (int k = 0; k < WORDS; k++) begin
          rd(rg[g], k, v); chk("R2 clear readback (R3 word isolation)", v, model[g][k]);
        end
      end
    end

    // R10 write-only addresses read zero
    foreach (sg[g]) begin
      rd(sg[g], 0, v); chk("R10 set reads 0", v, 32'h0);
      rd(cg[g], 1, v); chk("R10 clear reads 0", v, 32'h0);
    end
    rd(G_ACK, 0, v); chk("R10 ack reads 0", v, 32'h0);

    // restore
    for (int w = 0; w < WORDS; w++) begin
      wr(G_SOFT_CLR, w, '1); wr(G_SENS_CLR, w, '1);
      wr(G_POL_CLR, w, '1);  wr(G_MASK_SET, w, '1);
      wr(G_ACK, w, '1);
    end
    idle(4);
    for (int w = 0; w < WORDS; w++) begin
      rd(G_STATUS, w, v); chk("R8 no event from config changes", v, 32'h0);
    end

    // R9 enable gating, then open everything, rising edges
    for (int w = 0; w < WORDS; w++) begin
      wr(G_POL_SET, w, '1); wr(G_MASK_CLR, w, '1);
    end
    wr(G_SOFT_SET, 0, 32'h1);
    idle(4);
    chk("R9 enable zero blocks irq", {31'd0, irq}, 32'd0);
    for (int w = 0; w < WORDS; w++) wr(G_ENABLE, w, '1);
    idle(3);
    chk("R9 irq with enable", {31'd0, irq}, 32'd1);
    wr(G_SOFT_CLR, 0, 32'h1);
    idle(3);
    chk("R9 irq drops", {31'd0, irq}, 32'd0);

    // R4 / R3 / R6 per-line edge sweep
    for (int n = 0; n < NL; n++) begin
      logic [31:0] bitv;
      bitv = 32'h1 << (n % 32);
      pin[n] = 1'b1;
      idle(6);
      rd(G_STATUS, n / 32, v); chk("R4 rising latched (R3 bit map)", v, bitv);
      rd(G_STATUS, 1 - n / 32, v); chk("R3 other word clear", v, 32'h0);
      chk("R9 irq from edge", {31'd0, irq}, 32'd1);
      pin[n] = 1'b0;
      idle(6);
      rd(G_STATUS, n / 32, v); chk("R4 stays after pin returns", v, bitv);
      wr(G_ACK, n / 32, bitv);
      idle(3);
      rd(G_STATUS, n / 32, v); chk("R6 ack clears", v, 32'h0);
      chk("R9 irq clear", {31'd0, irq}, 32'd0);
    end

    // R4 falling polarity on line 5
    wr(G_POL_CLR, 0, 32'h20);
    pin[5] = 1'b1; idle(6);
    rd(G_STATUS, 0, v); chk("R4 rise ignored when falling", v, 32'h0);
    pin[5] = 1'b0; idle(6);
    rd(G_STATUS, 0, v); chk("R4 falling latched", v, 32'h20);
    wr(G_ACK, 0, 32'h20);

    // R8 polarity flip on steady pins (line 7 high, line 9 low)
    pin[7] = 1'b1; idle(6);
    wr(G_ACK, 0, '1); idle(2);
    wr(G_POL_CLR, 0, 32'h280); idle(6);
    rd(G_STATUS, 0, v); chk("R8 steady pins, pol to falling", v, 32'h0);
    wr(G_POL_SET, 0, 32'h280); idle(6);
    rd(G_STATUS, 0, v); chk("R8 steady pins, pol to rising", v, 32'h0);
    pin[7] = 1'b0; idle(6);
    rd(G_STATUS, 0, v); chk("R8 falling not an event on rising line", v, 32'h0);

    // R6 ack of zero bits leaves latched lines
    pin[20] = 1'b1; idle(6);
    wr(G_ACK, 0, 32'hFFEF_FFFF); idle(2);
    rd(G_STATUS, 0, v); chk("R6 other ack bits no effect", v, 32'h0010_0000);
    pin[20] = 1'b0;
    wr(G_ACK, 0, 32'h0010_0000); idle(6);

    // R5 level mode on line 10
    wr(G_SENS_SET, 0, 32'h400);
    pin[10] = 1'b1; idle(6);
    rd(G_STATUS, 0, v); chk("R5 high level pending", v, 32'h400);
    wr(G_ACK, 0, 32'h400); idle(2);
    rd(G_STATUS, 0, v); chk("R5 ack no effect", v, 32'h400);
    pin[10] = 1'b0; idle(6);
    rd(G_STATUS, 0, v); chk("R5 follows pin low", v, 32'h0);
    wr(G_POL_CLR, 0, 32'h400); idle(2);
    rd(G_STATUS, 0, v); chk("R5 low level pending", v, 32'h400);
    wr(G_SENS_CLR, 0, 32'h400); idle(4);
    rd(G_STATUS, 0, v); chk("R8 leaving level mode no event", v, 32'h0);

    // R7 soft interrupt on line 40
    wr(G_SOFT_SET, 1, 32'h100); idle(3);
    rd(G_STATUS, 1, v); chk("R7 soft sets status", v, 32'h100);
    chk("R7 soft raises irq", {31'd0, irq}, 32'd1);
    wr(G_ACK, 1, '1); idle(2);
    rd(G_STATUS, 1, v); chk("R7 survives ack", v, 32'h100);
    // R9 mask and enable gating of the soft line
    wr(G_MASK_SET, 1, 32'h100); idle(3);
    chk("R9 masked line quiet", {31'd0, irq}, 32'd0);
    wr(G_MASK_CLR, 1, 32'h100); idle(3);
    chk("R9 unmasked line fires", {31'd0, irq}, 32'd1);
    wr(G_ENABLE, 1, 32'hFFFF_FEFF); idle(3);
    chk("R9 enable bit gates", {31'd0, irq}, 32'd0);
    wr(G_ENABLE, 1, '1);
    wr(G_SOFT_CLR, 1, 32'h100); idle(3);
    rd(G_STATUS, 1, v); chk("R7 soft clear", v, 32'h0);
    chk("R7 irq gone", {31'd0, irq}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule